// File: doc/BRIEF.md
# Cartridge Program Bank Controller

This block sits on the CPU side of an 8-bit console cartridge and steers the upper program-ROM address lines. Any CPU write with address bit 15 set lands in a small register file; the low address nibble picks the register, so the registers repeat every 16 bytes across the whole upper half of the map. One register picks the 16 KB bank seen in the lower ROM window at 0x8000–0xBFFF. The upper window at 0xC000–0xFFFF always shows the last 16 KB bank of the current 256 KB outer block.

The outer block is built from bit 0 of four registers at offsets 0–3. Each register holds its own bit, and any one of them set selects the upper 256 KB half. A control register at offset 0xD does two jobs. It switches on the 8 KB work RAM at 0x6000–0x7FFF, and it holds the clock, data and drive-enable state of a two-wire serial EEPROM. When the work RAM is off, CPU reads from 0x6000–0x7FFF return the EEPROM data line on bit 4, and the other bits come from the open-bus value.

Top module: `prg_bank_ctrl`

## Requirements
- R1: After reset every register is zero. The lower window then reads bank 0 of outer block 0, the work-RAM select is low, the EEPROM clock and data outputs are low, and the data drive enable is low, so the line is released and pulled high.
- R2: A write with cpu_addr[15]=1 and cpu_addr[3:0]=8 stores cpu_wdata[3:0] as the switchable bank. From the next cycle on, an access at 0x8000–0xBFFF gives prg_addr_hi = {outer, bank}.
- R3: An access at 0xC000–0xFFFF gives prg_addr_hi[3:0] = 4'hF, with the current outer bit in prg_addr_hi[4], whatever register 8 holds.
- R4: Writes to offsets 0, 1, 2 and 3 each latch cpu_wdata[0] into a register of their own. The outer bit (prg_addr_hi[4]) is the OR of those four bits, so clearing one register leaves the outer bit set while another one still holds a 1.
- R5: Bit 5 of the control register (offset 0xD) enables the work RAM. wram_ce is high only when that bit is set and cpu_addr lies in 0x6000–0x7FFF. Writing 0 to the bit turns the RAM off.
- R6: Control register bit 2 drives eep_scl, bit 6 drives eep_sda_o, and bit 7 drives eep_sda_oe (1 means the data line is driven). All three change in the cycle after the write.
- R7: While the work RAM is off, a read (cpu_rd=1) at 0x6000–0x7FFF sets cpu_rdata_oe, and cpu_rdata is cpu_open_bus with bit 4 replaced by eep_sda_i. In every other case cpu_rdata_oe is 0 and cpu_rdata is 0.
- R8: Writes with cpu_addr[15]=0 have no effect. Neither do writes to the unused offsets (anything other than 0–3, 8 and 0xD).
- R9: prg_ce equals cpu_addr[15]. When it is low, prg_addr_hi is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_open_bus | input | 8 | Value left on the data bus by the previous cycle |
| eep_sda_i | input | 1 | EEPROM data line as sensed |
| prg_ce | output | 1 | Program ROM select |
| prg_addr_hi | output | 5 | ROM address bits 18:14 as {outer, bank} |
| wram_ce | output | 1 | Work RAM select |
| cpu_rdata | output | 8 | Read data for the EEPROM status read |
| cpu_rdata_oe | output | 1 | cpu_rdata drives the CPU bus |
| eep_scl | output | 1 | EEPROM clock |
| eep_sda_o | output | 1 | EEPROM data out |
| eep_sda_oe | output | 1 | EEPROM data drive enable |

## Verification
The address decode outputs (prg_ce, prg_addr_hi, wram_ce, cpu_rdata, cpu_rdata_oe) depend combinationally on the address and read inputs. They are therefore due in the same cycle as the address. A register write shows up one clock later, both on the EEPROM pins and in the decode. The driver holds each write strobe for exactly one rising edge and probes only at a later falling edge. The monitor compares 3 ns after that falling edge, so every expected item is checked after the write has landed and well away from any clock edge.

// File: rtl/prg_bank_pkg.sv
// Package: shared constants and the control-register view used by the
// program bank controller. Assumes a 16-bit CPU address and 8-bit data.
package prg_bank_pkg;
    // Register offsets (low address nibble) that the decode depends on
    localparam logic [3:0] SEL_BANK = 4'h8;
    localparam logic [3:0] SEL_CTRL = 4'hD;

    // Bit positions inside the control register
    localparam int CTRL_SCL_BIT  = 2;
    localparam int CTRL_WRAM_BIT = 5;
    localparam int CTRL_SDA_BIT  = 6;
    localparam int CTRL_DRV_BIT  = 7;

    // Bit of cpu_rdata that carries the EEPROM data line
    localparam int EEP_RD_BIT = 4;

    // Decoded control register
    typedef struct packed {
        logic drive;
        logic sda;
        logic wram_en;
        logic scl;
    } ctrl_t;
endpackage

// File: rtl/prg_bank_regs.sv
// Register file: stores the bank select, the outer-block bits and the
// control register. Assumes wr_en is already qualified by address bit 15.
module prg_bank_regs
    import prg_bank_pkg::*;
#(
    parameter int BANK_W     = 4,
    parameter int OUTER_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        sel,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] bank,
    output logic              outer,
    output ctrl_t             ctrl
);
    logic [OUTER_REGS-1:0] outer_q;

    // Switchable bank register, written at offset 8
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank <= '0;
        else if (wr_en && sel == SEL_BANK)
            bank <= wdata[BANK_W-1:0];
    end

    // One latch bit per outer-block register, each at its own offset
    for (genvar i = 0; i < OUTER_REGS; i++) begin : g_outer
        always_ff @(posedge clk) begin
            if (!rst_n)
                outer_q[i] <= 1'b0;
            else if (wr_en && sel == 4'(i))
                outer_q[i] <= wdata[0];
        end
    end

    // The outer block is selected if any of the registers holds a 1
    always_comb outer = |outer_q;

    // Control register at offset 0xD; reset leaves the EEPROM data line released
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && sel == SEL_CTRL) begin
            ctrl.drive   <= wdata[CTRL_DRV_BIT];
            ctrl.sda     <= wdata[CTRL_SDA_BIT];
            ctrl.wram_en <= wdata[CTRL_WRAM_BIT];
            ctrl.scl     <= wdata[CTRL_SCL_BIT];
        end
    end
endmodule

// File: rtl/prg_window_map.sv
// Window map: turns the CPU address into the ROM select and the upper
// ROM address bits. Assumes the 0xC000 window holds the last bank of the outer block.
module prg_window_map #(
    parameter int BANK_W = 4
) (
    input  logic              addr_hi,
    input  logic              addr_fixed,
    input  logic [BANK_W-1:0] bank,
    input  logic              outer,
    output logic              prg_ce,
    output logic [BANK_W:0]   prg_hi
);
    localparam logic [BANK_W-1:0] FIXED_BANK = '1;

    // Choose the switchable or the fixed bank and prepend the outer bit
    always_comb begin
        prg_ce = addr_hi;
        if (!addr_hi)
            prg_hi = '0;
        else if (addr_fixed)
            prg_hi = {outer, FIXED_BANK};
        else
            prg_hi = {outer, bank};
    end
endmodule

// File: rtl/prg_wram_port.sv
// Work-RAM port: selects the RAM at 0x6000-0x7FFF and, while the RAM is
// off, returns the EEPROM data line on the CPU read bus.
module prg_wram_port
    import prg_bank_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        wram_en,
    input  logic [7:0]  open_bus,
    input  logic        sda_i,
    output logic        wram_ce,
    output logic [7:0]  rdata,
    output logic        rdata_oe
);
    logic in_range;

    // Decode the 8 KB work-RAM range
    always_comb in_range = (cpu_addr[15:13] == 3'b011);

    // RAM select, or the EEPROM status read when the RAM is off
    always_comb begin
        wram_ce  = in_range && wram_en;
        rdata_oe = in_range && !wram_en && cpu_rd;
        rdata    = '0;
        if (rdata_oe) begin
            rdata             = open_bus;
            rdata[EEP_RD_BIT] = sda_i;
        end
    end
endmodule

// File: rtl/prg_bank_ctrl.sv
// Top level: program bank controller. Registers repeat every 16 bytes across
// 0x8000-0xFFFF. Assumes cpu_wr is high for a single clock per CPU write.
module prg_bank_ctrl
    import prg_bank_pkg::*;
#(
    parameter int BANK_W     = 4,
    parameter int OUTER_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_open_bus,
    input  logic              eep_sda_i,
    output logic              prg_ce,
    output logic [BANK_W:0]   prg_addr_hi,
    output logic              wram_ce,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rdata_oe,
    output logic              eep_scl,
    output logic              eep_sda_o,
    output logic              eep_sda_oe
);
    logic              reg_wr;
    logic [BANK_W-1:0] bank;
    logic              outer;
    ctrl_t             ctrl;

    // Register writes need address bit 15
    always_comb reg_wr = cpu_wr && cpu_addr[15];

    prg_bank_regs #(.BANK_W(BANK_W), .OUTER_REGS(OUTER_REGS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .sel   (cpu_addr[3:0]),
        .wdata (cpu_wdata),
        .bank  (bank),
        .outer (outer),
        .ctrl  (ctrl)
    );

    prg_window_map #(.BANK_W(BANK_W)) u_map (
        .addr_hi    (cpu_addr[15]),
        .addr_fixed (cpu_addr[14]),
        .bank       (bank),
        .outer      (outer),
        .prg_ce     (prg_ce),
        .prg_hi     (prg_addr_hi)
    );

    prg_wram_port u_wram (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .wram_en  (ctrl.wram_en),
        .open_bus (cpu_open_bus),
        .sda_i    (eep_sda_i),
        .wram_ce  (wram_ce),
        .rdata    (cpu_rdata),
        .rdata_oe (cpu_rdata_oe)
    );

    // EEPROM pins come straight from the control register
    always_comb begin
        eep_scl    = ctrl.scl;
        eep_sda_o  = ctrl.sda;
        eep_sda_oe = ctrl.drive;
    end
endmodule

// File: rtl/prg_bank_ctrl_chk.sv
// Checker: port-level properties of the program bank controller, bound to
// every instance of the top module.
module prg_bank_ctrl_chk #(
    parameter int BANK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr,
    input logic              eep_sda_i,
    input logic [BANK_W:0]   prg_addr_hi,
    input logic              wram_ce,
    input logic [7:0]        cpu_rdata,
    input logic              cpu_rdata_oe,
    input logic              eep_scl,
    input logic              eep_sda_o,
    input logic              eep_sda_oe
);
    // A bank write is seen in the lower window on the next cycle
    assert_bank_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15] && cpu_addr[3:0] == 4'h8)
        |=> (cpu_addr[15:14] != 2'b10 || prg_addr_hi[BANK_W-1:0] == $past(cpu_wdata[BANK_W-1:0])));

    // The upper window always shows the last bank
    assert_fixed_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11) |-> (prg_addr_hi[BANK_W-1:0] == '1));

    // wram_ce only inside the work-RAM range
    assert_wram_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wram_ce |-> (cpu_addr[15:13] == 3'b011));

    // The EEPROM pins hold unless a register write occurs
    assert_pins_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15]) |=> ($stable(eep_scl) && $stable(eep_sda_o) && $stable(eep_sda_oe)));

    // The status read carries the sensed data line on bit 4
    assert_status_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_oe |-> (cpu_rdata[4] == eep_sda_i && !wram_ce));
endmodule

bind prg_bank_ctrl prg_bank_ctrl_chk #(.BANK_W(BANK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_wr       (cpu_wr),
    .eep_sda_i    (eep_sda_i),
    .prg_addr_hi  (prg_addr_hi),
    .wram_ce      (wram_ce),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe),
    .eep_scl      (eep_scl),
    .eep_sda_o    (eep_sda_o),
    .eep_sda_oe   (eep_sda_oe)
);

// File: tb/prg_bank_ctrl_tb.sv
// Scoreboard bench: the driver keeps its own model of the registers and pushes
// expected outputs; the monitor pops and compares them after each falling edge.
module prg_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_open_bus = 8'h00;
    logic        eep_sda_i = 1'b0;
    logic        prg_ce;
    logic [4:0]  prg_addr_hi;
    logic        wram_ce;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic        eep_scl, eep_sda_o, eep_sda_oe;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic       ce;
        logic [4:0] hi;
        logic       wram;
        logic [7:0] rd;
        logic       oe;
        logic [2:0] pins;
        string      req;
    } exp_t;

    exp_t sb[$];

    // Model of the register file, kept from the requirements
    logic [3:0] m_bank = '0;
    logic [3:0] m_outer = '0;
    logic [7:0] m_ctrl = '0;

    always #5 clk = ~clk;

    prg_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_open_bus(cpu_open_bus),
        .eep_sda_i(eep_sda_i), .prg_ce(prg_ce), .prg_addr_hi(prg_addr_hi),
        .wram_ce(wram_ce), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
        .eep_scl(eep_scl), .eep_sda_o(eep_sda_o), .eep_sda_oe(eep_sda_oe)
    );

    // Driver: one write strobe held for a single rising edge; model updated
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a[15]) begin
            if (a[3:0] == 4'h8) m_bank = d[3:0];
            if (a[3:0] < 4'h4) m_outer[a[1:0]] = d[0];
            if (a[3:0] == 4'hD) m_ctrl = d;
        end
    endtask

    // Driver: present an address and push the outputs the requirements predict
    task automatic probe(input logic [15:0] a, input logic rd, input logic [7:0] ob,
                         input logic sda, input string req);
        exp_t e;
        logic outer;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_open_bus = ob; eep_sda_i = sda;
        outer  = |m_outer;
        e.ce   = a[15];
        e.hi   = !a[15] ? 5'd0 : (a[14] ? {outer, 4'hF} : {outer, m_bank});
        e.wram = (a[15:13] == 3'b011) && m_ctrl[5];
        e.oe   = (a[15:13] == 3'b011) && !m_ctrl[5] && rd;
        e.rd   = e.oe ? {ob[7:5], sda, ob[3:0]} : 8'h00;
        e.pins = {m_ctrl[2], m_ctrl[6], m_ctrl[7]};
        e.req  = req;
        sb.push_back(e);
    endtask

    // Monitor: compare every pending item 3 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                exp_t e;
                logic [18:0] act, exp;
                e = sb.pop_front();
                act = {prg_ce, prg_addr_hi, wram_ce, cpu_rdata, cpu_rdata_oe,
                       eep_scl, eep_sda_o, eep_sda_oe};
                exp = {e.ce, e.hi, e.wram, e.rd, e.oe, e.pins};
                vectors++;
                if (act !== exp) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", e.req, cpu_addr, act, exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        probe(16'h8000, 1'b0, 8'h00, 1'b0, "R1");
        probe(16'hC123, 1'b0, 8'h00, 1'b0, "R1_R3");
        probe(16'h6000, 1'b1, 8'hA5, 1'b1, "R1_R7");
        // R9: low half of the map
        probe(16'h1234, 1'b0, 8'h00, 1'b0, "R9");
        // R2: bank select
        wr(16'h8008, 8'h05);
        probe(16'h9234, 1'b0, 8'h00, 1'b0, "R2");
        probe(16'hE000, 1'b0, 8'h00, 1'b0, "R3");
        wr(16'hFFF8, 8'h1A);
        probe(16'hBFFF, 1'b0, 8'h00, 1'b0, "R2_mirror");
        // R8: ignored writes
        wr(16'h7008, 8'h03);
        probe(16'h8000, 1'b0, 8'h00, 1'b0, "R8_low");
        wr(16'h8009, 8'hFF);
        probe(16'h8000, 1'b0, 8'h00, 1'b0, "R8_unused");
        wr(16'h600D, 8'hE4);
        probe(16'h6000, 1'b1, 8'h3C, 1'b0, "R8_ctrl_low");
        // R4: outer block as OR of four bits
        wr(16'h8001, 8'h01);
        probe(16'h8000, 1'b0, 8'h00, 1'b0, "R4_set");
        probe(16'hC000, 1'b0, 8'h00, 1'b0, "R4_R3");
        wr(16'h8003, 8'h01);
        wr(16'h8001, 8'h00);
        probe(16'hA000, 1'b0, 8'h00, 1'b0, "R4_held");
        wr(16'h8003, 8'hFE);
        probe(16'hA000, 1'b0, 8'h00, 1'b0, "R4_clear");
        wr(16'h8000, 8'h01); wr(16'h8002, 8'h01);
        probe(16'hD000, 1'b0, 8'h00, 1'b0, "R4_multi");
        // R5: work RAM enable
        wr(16'h800D, 8'h20);
        probe(16'h6000, 1'b1, 8'hFF, 1'b1, "R5_on");
        probe(16'h7FFF, 1'b0, 8'h00, 1'b0, "R5_top");
        probe(16'h5FFF, 1'b1, 8'h00, 1'b1, "R5_below");
        probe(16'h8000, 1'b1, 8'h00, 1'b0, "R5_above");
        // R6: EEPROM pins
        wr(16'h800D, 8'hC4);
        probe(16'h7000, 1'b1, 8'h5A, 1'b1, "R6_R7");
        wr(16'h800D, 8'h40);
        probe(16'h7000, 1'b1, 8'hFF, 1'b0, "R6_R7_zero");
        wr(16'h800D, 8'h84);
        probe(16'h7000, 1'b0, 8'hFF, 1'b1, "R6_R7_noread");
        wr(16'h800D, 8'h00);
        probe(16'h6800, 1'b1, 8'h00, 1'b1, "R7");
        // R1 again: reset mid-run restores everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_bank = '0; m_outer = '0; m_ctrl = '0;
        probe(16'hA000, 1'b0, 8'h00, 1'b0, "R1_rerst");
        probe(16'hF000, 1'b0, 8'h00, 1'b0, "R1_R3_rerst");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule